// File: doc/BRIEF.md
# BCD Clock-Calendar Core with Alarms

This core keeps wall-clock time and a calendar as packed BCD bytes. It tracks seconds, minutes, hours (24-hour), date, month and a two-digit year, and it keeps a separate day-of-week counter. Time moves forward on a tick input. A parameter sets how many tick pulses make one second, and an internal sub-second counter divides the ticks down to that rate. The oscillator, battery switching, non-volatile storage and the serial bus itself all sit outside this core.

A host bus interface reaches the core through a flat byte-wide register port. Writes use one port and reads use another. The bus logic pulses `capture` at the point where a read transfer is acknowledged. That pulse freezes the live time into a snapshot register, so a multi-byte read sees one consistent instant while the live counter keeps advancing.

Each alarm has per-field compare values and a field-enable mask. A matching alarm sets a sticky flag. When its interrupt enable is also set, the flag pulls the shared active-low interrupt output low.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset, the live time and the snapshot are 00:00:00 with day-of-week 0, date 01, month 01 and year 00. All alarm compare values, masks, interrupt enables and flags are 0, and `irq_n` is 1.
- R2: The time advances by one second on every TICKS_PER_SEC-th `tick` pulse. Seconds and minutes go from 59 to 00 with a carry. Hours go from 23 to 00 and carry into the date and the day-of-week. All of these fields are BCD.
- R3: The day-of-week (address 3, bits [2:0]) steps 0,1,...,6 and wraps to 0 on each day carry. A write keeps only bits [2:0].
- R4: The date wraps to 01 after 30 in months 04, 06, 09 and 11. It wraps after 29 in month 02 when the binary value of the BCD year is divisible by 4, after 28 in other years' month 02, and after 31 in every other month. Month 12 wraps to 01 and carries into the year, and year 99 wraps to 00.
- R5: The time fields sit at addresses 0=seconds, 1=minutes, 2=hours, 3=day-of-week, 4=date, 5=month, 6=year. A write to one of them loads that field at the next clock edge. The write takes the place of any advance in that cycle and clears the sub-second count, so the next advance needs TICKS_PER_SEC more ticks.
- R6: A `capture` pulse copies the live time into the snapshot at the clock edge. Reads of addresses 0..6 return the snapshot only. The live time keeps counting between captures with no lost seconds.
- R7: Alarm i (i = 0..NUM_ALARMS-1) uses addresses 8*(i+1)+k as the compare byte for time field k (k = 0..6), and 8*(i+1)+7 as its field-enable mask in bits [6:0]. On each one-second advance, flag i sets if the mask is non-zero and every enabled field equals the new time. Captures and reads do not change this.
- R8: Address 7 is the control register: bit i is alarm flag i and bit 4+i is interrupt enable i. Writing 0 to a flag bit clears it and writing 1 leaves it alone. An alarm match in the same cycle as the clear wins, so the flag ends up set.
- R9: `irq_n` is 0 exactly when some alarm has both its flag and its enable set. Clearing an enable masks only the interrupt, and the flag still sets and can still be read.
- R10: Addresses not named above read as 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Time-base pulse, one clock wide; TICKS_PER_SEC of them make a second |
| capture | input | 1 | Copies the live time into the read snapshot |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | 8 | Read data (combinational from registered state) |
| irq_n | output | 1 | Active-low alarm interrupt |

## Verification
The bench builds the core with TICKS_PER_SEC = 2 and NUM_ALARMS = 2. Two ticks per second makes the sub-second count matter: a write that lands halfway through a second can be seen pushing the next advance out by a full second, including when the write and a tick arrive in the same cycle. With two alarms, one enabled and one masked, the bench can show a flag that sets without raising the interrupt. It can also show a control write that clears one flag and keeps the other. A cycle-by-cycle reference model is compared against the core while the read address sweeps and captures fire at random. The run crosses a leap-year end of February and midnight, so the snapshot, the calendar carries and the alarm matching are all checked under load.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int FIELDS    = 7;
    localparam int F_SEC     = 0;
    localparam int F_MIN     = 1;
    localparam int F_HOUR    = 2;
    localparam int F_DOW     = 3;
    localparam int F_DATE    = 4;
    localparam int F_MON     = 5;
    localparam int F_YEAR    = 6;
    localparam int CTRL_ADDR = 7;
    localparam int IEN_LSB   = 4;

    // one byte per time field, field index equals its register address
    typedef logic [FIELDS-1:0][7:0] rtc_time_t;

    localparam rtc_time_t TIME_RESET = {8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00};

    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    function automatic logic [7:0] bcd_to_bin(input logic [7:0] v);
        return 8'(v[7:4]) * 8'd10 + 8'(v[3:0]);
    endfunction

    // last valid date (BCD) of a month
    function automatic logic [7:0] month_last(input logic [7:0] mon, input logic [7:0] year);
        logic [7:0] yb;
        yb = bcd_to_bin(year);
        case (mon)
            8'h02:                      return (yb[1:0] == 2'b00) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction
endpackage

// File: rtl/rtc_calendar_next.sv
module rtc_calendar_next
    import rtc_pkg::*;
(
    input  rtc_time_t cur,
    output rtc_time_t nxt
);
    logic c_min, c_hour, c_day, c_mon, c_year;

    always_comb begin
        nxt    = cur;
        c_min  = (cur[F_SEC] >= 8'h59);
        c_hour = c_min && (cur[F_MIN] >= 8'h59);
        c_day  = c_hour && (cur[F_HOUR] >= 8'h23);
        c_mon  = c_day && (cur[F_DATE] >= month_last(cur[F_MON], cur[F_YEAR]));
        c_year = c_mon && (cur[F_MON] >= 8'h12);

        nxt[F_SEC] = c_min ? 8'h00 : bcd_inc(cur[F_SEC]);
        if (c_min)  nxt[F_MIN]  = c_hour ? 8'h00 : bcd_inc(cur[F_MIN]);
        if (c_hour) nxt[F_HOUR] = c_day ? 8'h00 : bcd_inc(cur[F_HOUR]);
        if (c_day) begin
            nxt[F_DOW]  = (cur[F_DOW] >= 8'd6) ? 8'd0 : cur[F_DOW] + 8'd1;
            nxt[F_DATE] = c_mon ? 8'h01 : bcd_inc(cur[F_DATE]);
        end
        if (c_mon)  nxt[F_MON]  = c_year ? 8'h01 : bcd_inc(cur[F_MON]);
        if (c_year) nxt[F_YEAR] = (cur[F_YEAR] >= 8'h99) ? 8'h00 : bcd_inc(cur[F_YEAR]);
    end
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
    import rtc_pkg::*;
(
    input  rtc_time_t         when_t,
    input  rtc_time_t         target,
    input  logic [FIELDS-1:0] field_en,
    output logic              hit
);
    always_comb begin
        hit = |field_en;
        for (int k = 0; k < FIELDS; k++) begin
            if (field_en[k] && (when_t[k] != target[k])) hit = 1'b0;
        end
    end
endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core
    import rtc_pkg::*;
#(
    parameter  int TICKS_PER_SEC = 1,
    parameter  int NUM_ALARMS    = 2,   // 1..3
    localparam int ADDR_W        = $clog2(8 * (NUM_ALARMS + 1)),
    localparam int PRE_W         = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              capture,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              irq_n
);
    localparam int BLK_W = ADDR_W - 3;

    typedef struct packed {
        rtc_time_t                             live;
        rtc_time_t                             snap;
        logic [PRE_W-1:0]                      pre;
        logic [NUM_ALARMS-1:0]                 flag;
        logic [NUM_ALARMS-1:0]                 ien;
        rtc_time_t [NUM_ALARMS-1:0]            al_val;
        logic [NUM_ALARMS-1:0][FIELDS-1:0]     al_msk;
    } state_t;

    state_t                st_d, st_q;
    rtc_time_t             live_next;
    logic [NUM_ALARMS-1:0] hit;
    logic                  sec_adv;
    logic                  time_wr;

    rtc_calendar_next u_next (
        .cur (st_q.live),
        .nxt (live_next)
    );

    generate
        for (genvar i = 0; i < NUM_ALARMS; i++) begin : g_alarm
            rtc_alarm_match u_match (
                .when_t   (live_next),
                .target   (st_q.al_val[i]),
                .field_en (st_q.al_msk[i]),
                .hit      (hit[i])
            );
        end
    endgenerate

    always_comb begin
        st_d    = st_q;
        sec_adv = 1'b0;
        time_wr = wr_en && (wr_addr < ADDR_W'(FIELDS));

        if (capture) st_d.snap = st_q.live;

        if (time_wr) begin
            if (wr_addr == ADDR_W'(F_DOW)) st_d.live[wr_addr[2:0]] = {5'd0, wr_data[2:0]};
            else                           st_d.live[wr_addr[2:0]] = wr_data;
            st_d.pre = '0;
        end else if (tick) begin
            if (st_q.pre == PRE_W'(TICKS_PER_SEC - 1)) begin
                sec_adv   = 1'b1;
                st_d.pre  = '0;
                st_d.live = live_next;
            end else begin
                st_d.pre = st_q.pre + PRE_W'(1);
            end
        end

        if (wr_en && (wr_addr == ADDR_W'(CTRL_ADDR))) begin
            st_d.flag = st_q.flag & wr_data[NUM_ALARMS-1:0];
            st_d.ien  = wr_data[IEN_LSB +: NUM_ALARMS];
        end

        for (int i = 0; i < NUM_ALARMS; i++) begin
            if (wr_en && (wr_addr[ADDR_W-1:3] == BLK_W'(i + 1))) begin
                if (wr_addr[2:0] == 3'd7) st_d.al_msk[i] = wr_data[FIELDS-1:0];
                else                      st_d.al_val[i][wr_addr[2:0]] = wr_data;
            end
            // a match outranks a same-cycle clear
            if (sec_adv && hit[i]) st_d.flag[i] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.live <= TIME_RESET;
            st_q.snap <= TIME_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr < ADDR_W'(FIELDS)) begin
            rd_data = st_q.snap[rd_addr[2:0]];
        end else if (rd_addr == ADDR_W'(CTRL_ADDR)) begin
            rd_data[NUM_ALARMS-1:0]          = st_q.flag;
            rd_data[IEN_LSB +: NUM_ALARMS]   = st_q.ien;
        end
        for (int i = 0; i < NUM_ALARMS; i++) begin
            if (rd_addr[ADDR_W-1:3] == BLK_W'(i + 1)) begin
                if (rd_addr[2:0] == 3'd7) rd_data = {1'b0, st_q.al_msk[i]};
                else                      rd_data = st_q.al_val[i][rd_addr[2:0]];
            end
        end
    end

    assign irq_n = ~|(st_q.flag & st_q.ien);
endmodule

// File: rtl/rtc_core_checker.sv
module rtc_core_checker
    import rtc_pkg::*;
#(
    parameter int NUM_ALARMS = 2,
    parameter int ADDR_W     = 5
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  tick,
    input logic                  capture,
    input logic                  wr_en,
    input logic [ADDR_W-1:0]     wr_addr,
    input logic                  irq_n,
    input rtc_time_t             live,
    input rtc_time_t             snap,
    input logic [NUM_ALARMS-1:0] flag
);
    assert_reset_irq_R1: assert property (@(posedge clk) !rst_n |=> irq_n);

    assert_hold_time_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_en) |=> $stable(live));

    assert_snap_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(snap));

    assert_snap_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> (snap == $past(live)));

    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (wr_addr == ADDR_W'(CTRL_ADDR))) |=> ((~flag & $past(flag)) == '0));

    assert_no_flag_no_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag == '0) |-> irq_n);
endmodule

bind bcd_rtc_core rtc_core_checker #(
    .NUM_ALARMS (NUM_ALARMS),
    .ADDR_W     (ADDR_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .capture (capture),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .irq_n   (irq_n),
    .live    (st_q.live),
    .snap    (st_q.snap),
    .flag    (st_q.flag)
);

// File: tb/bcd_rtc_core_tb.sv
module bcd_rtc_core_tb;
    localparam int TPS = 2;
    localparam int NA  = 2;
    localparam int AW  = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b0;
    logic          capture = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic [AW-1:0] rd_addr;
    logic [7:0]    rd_data;
    logic          irq_n;

    logic          sweep_en = 1'b0;
    logic [AW-1:0] sweep_cnt = '0;
    logic [AW-1:0] dir_addr = '0;
    int            n_cmp = 0;
    int            n_bad = 0;
    bit            done = 0;
    bit            cmp_on = 0;

    always #4 clk = ~clk;

    assign rd_addr = sweep_en ? sweep_cnt : dir_addr;
    always @(negedge clk) sweep_cnt <= sweep_cnt + 1'b1;

    bcd_rtc_core #(.TICKS_PER_SEC(TPS), .NUM_ALARMS(NA)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .capture(capture),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq_n(irq_n)
    );

    // ---------------- behavioural reference model ----------------
    int m_t[7];
    int m_snap[7];
    int m_pre;
    int m_val[NA][8];
    bit m_flag[NA];
    bit m_ien[NA];

    function automatic int to_bcd(input int v);
        return (v / 10) * 16 + (v % 10);
    endfunction
    function automatic int from_bcd(input int v);
        return (v / 16) * 10 + (v % 16);
    endfunction
    function automatic int days_in(input int mon, input int yr);
        if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
        return 31;
    endfunction

    task automatic model_reset();
        m_t = '{0, 0, 0, 0, 1, 1, 0};
        m_snap = m_t;
        m_pre = 0;
        for (int i = 0; i < NA; i++) begin
            m_flag[i] = 0; m_ien[i] = 0;
            for (int k = 0; k < 8; k++) m_val[i][k] = 0;
        end
    endtask

    task automatic model_advance();
        m_t[0]++;
        if (m_t[0] == 60) begin m_t[0] = 0; m_t[1]++; end
        if (m_t[1] == 60) begin m_t[1] = 0; m_t[2]++; end
        if (m_t[2] == 24) begin
            m_t[2] = 0;
            m_t[3] = (m_t[3] + 1) % 7;
            m_t[4]++;
            if (m_t[4] > days_in(m_t[5], m_t[6])) begin
                m_t[4] = 1; m_t[5]++;
                if (m_t[5] == 13) begin m_t[5] = 1; m_t[6] = (m_t[6] + 1) % 100; end
            end
        end
    endtask

    task automatic model_step();
        bit adv;
        bit hits[NA];
        adv = 0;
        if (capture) m_snap = m_t;
        if (wr_en && wr_addr < 7) begin
            m_t[wr_addr] = (wr_addr == 3) ? int'(wr_data[2:0]) : from_bcd(int'(wr_data));
            m_pre = 0;
        end else if (tick) begin
            if (m_pre == TPS - 1) begin m_pre = 0; adv = 1; model_advance(); end
            else m_pre++;
        end
        for (int i = 0; i < NA; i++) begin
            hits[i] = adv && (m_val[i][7] != 0);
            for (int k = 0; k < 7; k++)
                if (m_val[i][7][k] && to_bcd(m_t[k]) != m_val[i][k]) hits[i] = 0;
        end
        if (wr_en && wr_addr == 7)
            for (int i = 0; i < NA; i++) begin
                m_flag[i] = m_flag[i] & wr_data[i];
                m_ien[i]  = wr_data[4 + i];
            end
        if (wr_en && wr_addr >= 8 && wr_addr < 8 * (NA + 1))
            m_val[wr_addr / 8 - 1][wr_addr % 8] = (wr_addr % 8 == 7) ? int'(wr_data[6:0]) : int'(wr_data);
        for (int i = 0; i < NA; i++) if (hits[i]) m_flag[i] = 1;
    endtask

    function automatic int exp_rd(input int a);
        int r;
        r = 0;
        if (a < 7) r = to_bcd(m_snap[a]);
        else if (a == 7) for (int i = 0; i < NA; i++) r = r | (int'(m_flag[i]) << i) | (int'(m_ien[i]) << (4 + i));
        else if (a < 8 * (NA + 1)) r = m_val[a / 8 - 1][a % 8];
        return r;
    endfunction

    function automatic bit exp_irq();
        bit any;
        any = 0;
        for (int i = 0; i < NA; i++) any |= m_flag[i] & m_ien[i];
        return !any;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) model_reset();
        else model_step();
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // every-cycle comparison against the model
    always @(posedge clk) begin
        #2;
        if (cmp_on) begin
            string t;
            int a;
            a = int'(rd_addr);
            t = (a < 7) ? "R6 snapshot read" : (a == 7) ? "R8 control read" :
                (a < 8 * (NA + 1)) ? "R7 alarm read" : "R10 unmapped read";
            chk(t, int'(rd_data), exp_rd(a));
            chk("R9 irq_n", int'(irq_n), int'(exp_irq()));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input int a, input int d);
        @(negedge clk); wr_en = 1; wr_addr = AW'(a); wr_data = 8'(d);
        @(negedge clk); wr_en = 0;
    endtask

    task automatic set_time(input int s, input int mi, input int h, input int dw,
                            input int dt, input int mo, input int y);
        wr(0, s); wr(1, mi); wr(2, h); wr(3, dw); wr(4, dt); wr(5, mo); wr(6, y);
    endtask

    task automatic ticks(input int n);
        for (int j = 0; j < n; j++) begin
            @(negedge clk); tick = 1;
            @(negedge clk); tick = 0;
        end
    endtask

    task automatic peek(input int a, input int exp, input string tag, input bit cap);
        @(negedge clk); sweep_en = 0; dir_addr = AW'(a); capture = cap;
        @(posedge clk); #2;
        chk(tag, int'(rd_data), exp);
        @(negedge clk); capture = 0; sweep_en = 1;
    endtask

    task automatic chk_irq(input int exp, input string tag);
        @(posedge clk); #2;
        chk(tag, int'(irq_n), exp);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        cmp_on = 1;
        sweep_en = 1;

        // R1 reset values
        peek(0, 8'h00, "R1 sec", 1); peek(2, 8'h00, "R1 hour", 1);
        peek(3, 8'h00, "R1 dow", 1); peek(4, 8'h01, "R1 date", 1);
        peek(5, 8'h01, "R1 month", 1); peek(6, 8'h00, "R1 year", 1);
        peek(7, 8'h00, "R1 control", 0); peek(15, 8'h00, "R1 mask", 0);
        chk_irq(1, "R1 irq_n");

        // R2 R3 R4 full rollover at year end
        set_time('h58, 'h59, 'h23, 6, 'h31, 'h12, 'h99);
        ticks(2 * TPS);
        peek(0, 8'h00, "R2 sec wrap", 1); peek(1, 8'h00, "R2 min wrap", 1);
        peek(2, 8'h00, "R2 hour wrap", 1); peek(3, 8'h00, "R3 dow wrap", 1);
        peek(4, 8'h01, "R4 date wrap", 1); peek(5, 8'h01, "R4 month wrap", 1);
        peek(6, 8'h00, "R4 year wrap", 1);

        // R4 month lengths
        set_time('h59, 'h59, 'h23, 2, 'h28, 'h02, 'h24); ticks(TPS);
        peek(4, 8'h29, "R4 leap feb 29", 1);
        peek(3, 8'h03, "R3 dow step", 1);
        wr(0, 'h59); wr(1, 'h59); wr(2, 'h23); ticks(TPS);
        peek(4, 8'h01, "R4 leap feb end", 1); peek(5, 8'h03, "R4 to march", 1);
        set_time('h59, 'h59, 'h23, 0, 'h28, 'h02, 'h23); ticks(TPS);
        peek(4, 8'h01, "R4 common feb end", 1);
        set_time('h59, 'h59, 'h23, 0, 'h30, 'h04, 'h23); ticks(TPS);
        peek(5, 8'h05, "R4 april end", 1);
        set_time('h59, 'h59, 'h23, 0, 'h30, 'h01, 'h23); ticks(TPS);
        peek(4, 8'h31, "R4 jan 31", 1);

        // R5 write restarts the sub-second count
        wr(0, 'h10); ticks(1); wr(0, 'h20); ticks(1);
        peek(0, 8'h20, "R5 no early advance", 1);
        ticks(1); peek(0, 8'h21, "R5 advance after full second", 1);
        @(negedge clk); wr_en = 1; wr_addr = 0; wr_data = 8'h30; tick = 1;
        @(negedge clk); wr_en = 0; tick = 0;
        peek(0, 8'h30, "R5 write beats tick", 1);
        ticks(1); peek(0, 8'h30, "R5 restart after same-cycle write", 1);
        ticks(1); peek(0, 8'h31, "R5 next second", 1);

        // R6 snapshot holds while live time runs
        wr(0, 'h40); peek(0, 8'h40, "R6 capture", 1);
        ticks(3 * TPS);
        peek(0, 8'h40, "R6 snapshot frozen", 0);
        peek(0, 8'h43, "R6 no lost seconds", 1);

        // R7 R8 R9 alarms
        wr(0, 'h00); wr(8, 'h03); wr(15, 'h01); wr(7, 'h10);
        ticks(2 * TPS); chk_irq(1, "R7 no match yet");
        ticks(TPS); chk_irq(0, "R9 enabled alarm drives irq");
        peek(7, 8'h11, "R7 flag0 set", 0);
        wr(16, 'h04); wr(23, 'h01);
        ticks(TPS); peek(7, 8'h13, "R9 masked alarm still flags", 0);
        wr(7, 'h12); peek(7, 8'h12, "R8 write 0 clears, 1 keeps", 0);
        chk_irq(1, "R9 disabled flag masked");
        wr(7, 'h00); peek(7, 8'h00, "R8 clear all", 0);
        wr(0, 'h02); ticks(1);
        @(negedge clk); tick = 1; wr_en = 1; wr_addr = 7; wr_data = 8'h10;
        @(negedge clk); tick = 0; wr_en = 0;
        peek(7, 8'h11, "R8 set wins over clear", 0);
        chk_irq(0, "R9 irq after set-vs-clear");
        wr(7, 'h00);

        // R10 unmapped address
        wr(26, 'hFF); peek(26, 8'h00, "R10 unmapped", 0);

        // free run against the model: leap February into March, random captures
        set_time('h00, 'h55, 'h23, 4, 'h29, 'h02, 'h24);
        wr(8, 'h07); wr(15, 'h01); wr(7, 'h10);
        for (int c = 0; c < 4000; c++) begin
            @(negedge clk);
            tick = ~tick;
            capture = ($urandom % 5) == 0;
            wr_en = ($urandom % 97) == 0;
            wr_addr = 7; wr_data = 8'h10;
        end
        @(negedge clk); tick = 0; capture = 0; wr_en = 0;
        peek(5, 8'h03, "R4 free run reached march", 1);
        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule